// File: doc/BRIEF.md
# Repeated Write Address Watcher

This block watches the write address channel of an AXI4 port without driving it. For every write address handshake it tests whether the address lies in a window defined by two inputs: a lower bound and an upper bound, both inclusive. When the two bounds are equal, the window is a single address. A write that hits the window is a "hit". All decisions are made in logic in the same cycle as the handshake, so the block keeps up with the bus at full rate and needs no software in the path.

The first two hits are only counted. Once two hits have been seen, every later hit is treated as a repeated write to a protected location. The block stores the transaction's ID, address and burst length in a 16-entry trace FIFO and raises a one-cycle event pulse. A clear input starts counting from zero again. The trace FIFO is read from the output side with a pop strobe. If a capture arrives while the FIFO is full, the capture is discarded and a sticky overflow flag is raised.

Top module: `wr_window_watch`

## Requirements
- R1: A write is observed only in a cycle where `aw_valid` and `aw_ready` are both 1. A cycle with only one of them high changes nothing.
- R2: A write hits when `win_lo <= aw_addr <= win_hi` (unsigned). When `win_lo == win_hi`, only that one address hits. When `win_lo > win_hi`, no address hits.
- R3: The first and second hits after reset or clear raise `hit_count` to 1 and then 2. The new value is visible in the cycle after the handshake.
- R4: A hit that arrives while `hit_count` is 2 is captured and leaves `hit_count` at 2.
- R5: `evt_pulse` is high for exactly the one cycle after each captured handshake and low otherwise. It also pulses for a capture that the FIFO drops.
- R6: Each record holds ID, address and length. Records leave the FIFO oldest first. `trc_valid` is 1 whenever the FIFO holds a record, and `trc_pop` while `trc_valid` is 1 removes the head record.
- R7: With 16 records stored, a further capture is discarded. `trc_overflow` then goes to 1 and stays at 1 until reset.
- R8: `cnt_clear` sets `hit_count` to 0 in the next cycle. A write in the same cycle as `cnt_clear` is neither counted nor captured.
- R9: After reset, `hit_count` is 0 and `evt_pulse`, `trc_valid` and `trc_overflow` are all 0.
- R10: A write that misses the window leaves the count, the FIFO and the event output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| aw_valid | input | 1 | Snooped write address valid |
| aw_ready | input | 1 | Snooped write address ready |
| aw_id | input | ID_W | Snooped write ID |
| aw_addr | input | ADDR_W | Snooped write address |
| aw_len | input | LEN_W | Snooped burst length |
| win_lo | input | ADDR_W | Lower bound of the window, inclusive |
| win_hi | input | ADDR_W | Upper bound of the window, inclusive |
| cnt_clear | input | 1 | Sets the hit count to zero |
| hit_count | output | 2 | Number of hits counted so far, 0 to 2 |
| evt_pulse | output | 1 | One-cycle pulse for each capture |
| trc_valid | output | 1 | FIFO holds at least one record |
| trc_id | output | ID_W | ID of the head record |
| trc_addr | output | ADDR_W | Address of the head record |
| trc_len | output | LEN_W | Burst length of the head record |
| trc_pop | input | 1 | Removes the head record |
| trc_overflow | output | 1 | Sticky flag: a capture was dropped |

## Verification
A wrong count shows up one cycle after the next hit. A count stuck low delays the event past the third hit. A count that runs ahead fires the event on the first or second hit. A comparator off by one at either bound shows on the first write that lands exactly on a bound, because the count then moves when it should not, or stays when it should move. FIFO pointer or level errors appear when a record is popped with the wrong fields or in the wrong order. They also appear as an overflow flag raised at the wrong fill level, after sixteen captures at the latest.

// File: rtl/wwin_pkg.sv
// Shared definitions for the repeated write watcher.
// Assumes: the count only needs to reach the capture threshold.
package wwin_pkg;
    localparam int HIT_CNT_W = 2;
    localparam int HIT_THRESH = 2;

    typedef enum logic [1:0] {
        ACT_IDLE    = 2'd0,
        ACT_COUNT   = 2'd1,
        ACT_CAPTURE = 2'd2,
        ACT_CLEAR   = 2'd3
    } hit_act_e;
endpackage

// File: rtl/wwin_match.sv
// Window comparator: flags an accepted write whose address lies in [lo, hi].
// Assumes: an inverted window (lo > hi) is meant to match nothing.
module wwin_match #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    output logic              hit
);
    // Inclusive range test gated by the handshake
    always_comb begin
        hit = fire && (addr >= lo) && (addr <= hi);
    end

    // R2
    inverted_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo > hi) |-> !hit);
    // R1
    no_fire_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |-> !hit);
endmodule

// File: rtl/wwin_tally.sv
// Hit counter and action decoder: counts the first hits, then requests
// a capture and a registered event pulse for every later hit.
// Assumes: clear takes priority over a hit in the same cycle.
module wwin_tally
    import wwin_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hit,
    input  logic                 clear,
    output logic [HIT_CNT_W-1:0] count,
    output logic                 capture,
    output logic                 evt
);
    logic [HIT_CNT_W-1:0] cnt_q;
    logic                 evt_q;
    hit_act_e             act;

    // Pick this cycle's action from clear, hit and the stored count
    always_comb begin
        if (clear)
            act = ACT_CLEAR;
        else if (hit && (cnt_q >= HIT_CNT_W'(HIT_THRESH)))
            act = ACT_CAPTURE;
        else if (hit)
            act = ACT_COUNT;
        else
            act = ACT_IDLE;
    end

    assign capture = (act == ACT_CAPTURE);

    // Update the count
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (act == ACT_CLEAR)
            cnt_q <= '0;
        else if (act == ACT_COUNT)
            cnt_q <= cnt_q + 1'b1;
    end

    // Register the event so it is a clean one-cycle pulse
    always_ff @(posedge clk) begin
        if (!rst_n)
            evt_q <= 1'b0;
        else
            evt_q <= capture;
    end

    assign count = cnt_q;
    assign evt   = evt_q;

    // R4
    count_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= HIT_CNT_W'(HIT_THRESH));
    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));
    // R5
    evt_after_full_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit && !clear && (cnt_q == HIT_CNT_W'(HIT_THRESH)) |=> evt_q);
endmodule

// File: rtl/wwin_fifo.sv
// Trace FIFO: first-word-fall-through storage with a sticky drop flag.
// Assumes: a push while full is accepted only if a pop happens in the same cycle.
module wwin_fifo #(
    parameter int W     = 44,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic         valid,
    output logic [W-1:0] rdata,
    output logic         ovf
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [W-1:0]   mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [PTR_W:0] level;
    logic           ovf_q;
    logic           pop_ok, push_ok;

    assign pop_ok  = pop && (level != '0);
    assign push_ok = push && ((level < (PTR_W+1)'(DEPTH)) || pop_ok);

    // Write storage on an accepted push
    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wr_ptr] <= wdata;
    end

    // Advance pointers and fill level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            level <= level + (PTR_W+1)'(push_ok) - (PTR_W+1)'(pop_ok);
        end
    end

    // Latch a dropped capture until reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_q <= 1'b0;
        else if (push && !push_ok)
            ovf_q <= 1'b1;
    end

    assign valid = (level != '0);
    assign rdata = mem[rd_ptr];
    assign ovf   = ovf_q;

    // R7
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= (PTR_W+1)'(DEPTH));
    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);
    // R6
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) && !push |=> (level == '0));
endmodule

// File: rtl/wr_window_watch.sv
// Top: snoops write address handshakes, counts hits in a window and traces
// every hit after the second into a FIFO with a one-cycle event pulse.
// Assumes: the snooped channel follows the valid/ready rule; the block never drives it.
module wr_window_watch
    import wwin_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int ID_W      = 4,
    parameter int LEN_W     = 8,
    parameter int TRC_DEPTH = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 aw_valid,
    input  logic                 aw_ready,
    input  logic [ID_W-1:0]      aw_id,
    input  logic [ADDR_W-1:0]    aw_addr,
    input  logic [LEN_W-1:0]     aw_len,
    input  logic [ADDR_W-1:0]    win_lo,
    input  logic [ADDR_W-1:0]    win_hi,
    input  logic                 cnt_clear,
    output logic [HIT_CNT_W-1:0] hit_count,
    output logic                 evt_pulse,
    output logic                 trc_valid,
    output logic [ID_W-1:0]      trc_id,
    output logic [ADDR_W-1:0]    trc_addr,
    output logic [LEN_W-1:0]     trc_len,
    input  logic                 trc_pop,
    output logic                 trc_overflow
);
    localparam int REC_W = ID_W + ADDR_W + LEN_W;

    logic             fire, hit, capture;
    logic [REC_W-1:0] rec_in, rec_out;

    assign fire   = aw_valid && aw_ready;
    assign rec_in = {aw_id, aw_addr, aw_len};

    wwin_match #(.ADDR_W(ADDR_W)) u_match (
        .clk(clk), .rst_n(rst_n), .fire(fire), .addr(aw_addr),
        .lo(win_lo), .hi(win_hi), .hit(hit)
    );

    wwin_tally u_tally (
        .clk(clk), .rst_n(rst_n), .hit(hit), .clear(cnt_clear),
        .count(hit_count), .capture(capture), .evt(evt_pulse)
    );

    wwin_fifo #(.W(REC_W), .DEPTH(TRC_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(capture), .wdata(rec_in),
        .pop(trc_pop), .valid(trc_valid), .rdata(rec_out), .ovf(trc_overflow)
    );

    assign {trc_id, trc_addr, trc_len} = rec_out;

    // R5
    evt_needs_prior_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pulse |-> $past(capture));
    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clear && !hit |=> $stable(hit_count));
endmodule

// File: tb/wr_window_watch_tb.sv
`timescale 1ns/1ps
module wr_window_watch_tb;
    localparam int AW = 32, IW = 4, LW = 8, DEP = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          aw_valid = 1'b0, aw_ready = 1'b0;
    logic [IW-1:0] aw_id = '0;
    logic [AW-1:0] aw_addr = '0;
    logic [LW-1:0] aw_len = '0;
    logic [AW-1:0] win_lo = 32'h100, win_hi = 32'h108;
    logic          cnt_clear = 1'b0;
    logic [1:0]    hit_count;
    logic          evt_pulse, trc_valid, trc_overflow;
    logic [IW-1:0] trc_id;
    logic [AW-1:0] trc_addr;
    logic [LW-1:0] trc_len;
    logic          trc_pop = 1'b0;

    int n_run = 0, n_fail = 0;
    int m_cnt = 0;
    bit m_ovf = 0;
    logic [IW-1:0] q_id   [64];
    logic [AW-1:0] q_addr [64];
    logic [LW-1:0] q_len  [64];
    int q_head = 0, q_n = 0;

    always #2.5 clk = ~clk;

    wr_window_watch #(.ADDR_W(AW), .ID_W(IW), .LEN_W(LW), .TRC_DEPTH(DEP)) u_dut (
        .clk(clk), .rst_n(rst_n), .aw_valid(aw_valid), .aw_ready(aw_ready),
        .aw_id(aw_id), .aw_addr(aw_addr), .aw_len(aw_len),
        .win_lo(win_lo), .win_hi(win_hi), .cnt_clear(cnt_clear),
        .hit_count(hit_count), .evt_pulse(evt_pulse), .trc_valid(trc_valid),
        .trc_id(trc_id), .trc_addr(trc_addr), .trc_len(trc_len),
        .trc_pop(trc_pop), .trc_overflow(trc_overflow)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // One snooped cycle plus the check one edge later (R1 R2 R3 R4 R5 R8 R10)
    task automatic do_aw(input bit v, input bit r, input logic [IW-1:0] id,
                         input logic [AW-1:0] a, input logic [LW-1:0] l, input bit clr);
        bit hit, cap;
        @(negedge clk);
        aw_valid = v; aw_ready = r; aw_id = id; aw_addr = a; aw_len = l; cnt_clear = clr;
        @(negedge clk);
        aw_valid = 1'b0; aw_ready = 1'b0; cnt_clear = 1'b0;
        hit = v && r && (a >= win_lo) && (a <= win_hi);
        cap = 0;
        if (clr) m_cnt = 0;
        else if (hit) begin
            if (m_cnt >= 2) cap = 1;
            else m_cnt++;
        end
        if (cap) begin
            if (q_n < DEP) begin
                q_id[(q_head+q_n)%64] = id; q_addr[(q_head+q_n)%64] = a;
                q_len[(q_head+q_n)%64] = l; q_n++;
            end else m_ovf = 1;
        end
        chk(hit_count == 2'(m_cnt), "R3/R8/R10 count", hit_count, m_cnt);
        chk(evt_pulse == cap, "R4/R5 event", evt_pulse, cap);
        chk(trc_overflow == m_ovf, "R7 overflow", trc_overflow, m_ovf);
        chk(trc_valid == (q_n > 0), "R6 valid", trc_valid, q_n > 0);
    endtask

    // Pop the head record and compare (R6)
    task automatic pop_chk();
        @(negedge clk);
        chk(trc_valid == 1'b1, "R6 valid before pop", trc_valid, 1);
        chk(trc_id == q_id[q_head], "R6 id", trc_id, q_id[q_head]);
        chk(trc_addr == q_addr[q_head], "R6 addr", trc_addr, q_addr[q_head]);
        chk(trc_len == q_len[q_head], "R6 len", trc_len, q_len[q_head]);
        trc_pop = 1'b1;
        @(negedge clk);
        trc_pop = 1'b0;
        q_head = (q_head + 1) % 64; q_n--;
        chk(evt_pulse == 1'b0, "R5 no event on pop", evt_pulse, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(hit_count == 0 && !evt_pulse && !trc_valid && !trc_overflow,
            "R9 reset", {hit_count, evt_pulse, trc_valid, trc_overflow}, 0);
        rst_n = 1'b1;

        // R1: handshake halves do not count
        do_aw(1, 0, 1, 32'h104, 0, 0);
        do_aw(0, 1, 1, 32'h104, 0, 0);

        // R2/R3/R4: sweep addresses across both window bounds
        for (int a = 32'hF8; a <= 32'h110; a += 2) begin
            do_aw(0, 0, 0, 0, 0, 1);
            for (int k = 0; k < 3; k++)
                do_aw(1, 1, IW'(a + k), AW'(a), LW'(k), 0);
            while (q_n > 0) pop_chk();
        end

        // R2: single-address window, then inverted window
        win_lo = 32'h200; win_hi = 32'h200;
        do_aw(0, 0, 0, 0, 0, 1);
        for (int a = 32'h1FF; a <= 32'h201; a++)
            for (int k = 0; k < 3; k++) do_aw(1, 1, 4'h3, AW'(a), 8'h7, 0);
        while (q_n > 0) pop_chk();
        win_lo = 32'h300; win_hi = 32'h2FF;
        do_aw(0, 0, 0, 0, 0, 1);
        for (int a = 32'h2FE; a <= 32'h301; a++) do_aw(1, 1, 4'h1, AW'(a), 8'h0, 0);

        // R8: write together with clear is ignored
        win_lo = 32'h0; win_hi = 32'hFFFF;
        do_aw(1, 1, 2, 32'h10, 1, 0);
        do_aw(1, 1, 2, 32'h10, 1, 0);
        do_aw(1, 1, 5, 32'h10, 1, 1);
        do_aw(1, 1, 2, 32'h10, 1, 0);

        // R7: fill the FIFO, then overflow; order kept on drain
        do_aw(0, 0, 0, 0, 0, 1);
        do_aw(1, 1, 0, 32'h40, 0, 0);
        do_aw(1, 1, 0, 32'h40, 0, 0);
        for (int i = 0; i < DEP + 2; i++)
            do_aw(1, 1, IW'(i), AW'(32'h1000 + 4*i), LW'(i), 0);
        while (q_n > 0) pop_chk();
        do_aw(0, 0, 0, 0, 0, 0);
        chk(trc_overflow == 1'b1, "R7 sticky after drain", trc_overflow, 1);

        finish_run();
    end
endmodule